// File: doc/BRIEF.md
# Windowed Integer Register File

This block holds the integer registers of a processor whose general registers are seen through a circular ring of overlapping windows. A 5-bit register index is turned into a storage location. The location depends on the current window pointer. A group of eight globals is shared by every window. The output group of each window is the same storage as the input group of its neighbour, so values pass between a caller and a callee without any copy. Two read ports and one write port serve the pipeline. Storage and indexing are 64 bits wide.

Two strobes move the pointer one window at a time. A save steps the pointer down and a restore steps it up, both modulo the window count. Before a move takes effect, the block tests the target window against a mask of invalid windows. If the target is marked invalid, the pointer stays where it is. The block then emits a one-cycle trap with a code, so that software can spill or fill the window and try the move again. The pointer and the mask can also be loaded directly.

Top module: `wrf_top`

## Requirements
- R1: After reset, `cwp` is 0, `wim` is 0, `trap_valid` is 0 and `trap_code` is 00.
- R2: Index 1..7 selects a global shared by all windows. Index 8..15 selects the outs, 16..23 the locals and 24..31 the ins of the current window. The outs of window w are the same storage as the ins of window (w-1) mod 8, so a value written to index 8+k is read at index 24+k after one save.
- R3: Index 0 always reads as zero on both read ports, and a write to index 0 changes nothing.
- R4: A save with a clear mask bit at target (cwp-1) mod 8 sets `cwp` to that target at the next clock edge.
- R5: A restore with a clear mask bit at target (cwp+1) mod 8 sets `cwp` to that target at the next clock edge.
- R6: A save or restore whose target mask bit is set leaves `cwp` and the register contents unchanged. In the cycle after the request, `trap_valid` is 1 for one cycle with `trap_code` 01 (overflow, on save) or 10 (underflow, on restore). In all other cycles `trap_code` is 00.
- R7: A pointer load (`cwp_wr_en`) overrides save and restore in the same cycle. Only the value mod 8 is kept, and `cwp[4:3]` always reads 0.
- R8: A mask load keeps bits 7:0 only, and `wim[31:8]` always reads 0. A save or restore in the same cycle as a mask load is checked against the mask that was in place before the load.
- R9: Save and restore asserted together, without a pointer load, change neither the pointer nor the trap outputs.
- R10: A read of the index being written in the same cycle (index not 0) returns the write data.
- R11: The two read ports resolve different indices independently in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_idx | input | 5 | Read port A register index |
| rd_a_data | output | 64 | Read port A data (combinational) |
| rd_b_idx | input | 5 | Read port B register index |
| rd_b_data | output | 64 | Read port B data (combinational) |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Write register index |
| wr_data | input | 64 | Write data |
| save_req | input | 1 | Move to the next window down |
| restore_req | input | 1 | Move to the next window up |
| cwp_wr_en | input | 1 | Load the window pointer |
| cwp_wr_val | input | 5 | Pointer load value |
| wim_wr_en | input | 1 | Load the invalid-window mask |
| wim_wr_val | input | 32 | Mask load value |
| cwp | output | 5 | Current window pointer |
| wim | output | 32 | Invalid-window mask |
| trap_valid | output | 1 | One-cycle trap pulse |
| trap_code | output | 2 | 01 overflow, 10 underflow, 00 none |

## Verification
The hardest state to reach is a trap taken at the wrap point of the ring, with live data in the shared out/in groups, so that a wrong aliasing or a wrong modulo step would show up as corrupted registers. Directed steps write the outs, save across window 0 to window 7, set mask bits at the exact target, and mix pointer loads, mask loads and simultaneous requests. A long random phase then draws sparse masks and frequent saves and restores. This makes the pointer travel round the ring many times and run into invalid windows from both sides, while a bench model of the storage checks every read.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
  typedef enum logic [1:0] {
    TRAP_NONE = 2'b00,
    TRAP_OVF  = 2'b01,
    TRAP_UNF  = 2'b10
  } trap_code_e;

  localparam int unsigned IDX_W = 5;
  localparam int unsigned GRP   = 8;
endpackage

// File: rtl/wrf_addr_map.sv
module wrf_addr_map
  import wrf_pkg::*;
#(
  parameter int unsigned PW = 3,
  parameter int unsigned AW = 8
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [PW-1:0]    ptr,
  output logic [AW-1:0]    phys,
  output logic             is_zero
);
  localparam int unsigned SLOT = 2 * GRP;

  logic [PW-1:0] owner;
  logic [AW-1:0] win_base;
  logic [AW-1:0] ofs;

  always_comb begin
    owner    = ptr;
    ofs      = AW'(idx[2:0]);
    if (idx[4:3] == 2'b01) begin
      owner = ptr - PW'(1);
    end
    win_base = AW'(GRP) + AW'(owner) * AW'(SLOT);
    unique case (idx[4:3])
      2'b00:   phys = ofs;
      2'b01:   phys = win_base + AW'(GRP) + ofs;
      2'b10:   phys = win_base + ofs;
      default: phys = win_base + AW'(GRP) + ofs;
    endcase
    is_zero = (idx == '0);
  end
endmodule

// File: rtl/wrf_storage.sv
module wrf_storage #(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned DEPTH = 136,
  parameter int unsigned AW    = 8,
  parameter int unsigned NRD   = 2
) (
  input  logic                       clk,
  input  logic                       we,
  input  logic [AW-1:0]              waddr,
  input  logic [XLEN-1:0]            wdata,
  input  logic [NRD-1:0][AW-1:0]     raddr,
  input  logic [NRD-1:0]             rzero,
  output logic [NRD-1:0][XLEN-1:0]   rdata
);
  logic [XLEN-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    logic hit;
    always_comb begin
      hit = we && (waddr == raddr[p]);
      if (rzero[p]) begin
        rdata[p] = '0;
      end else if (hit) begin
        rdata[p] = wdata;
      end else begin
        rdata[p] = mem[raddr[p]];
      end
    end
  end
endmodule

// File: rtl/wrf_window_ctl.sv
module wrf_window_ctl
  import wrf_pkg::*;
#(
  parameter int unsigned NWIN = 8,
  parameter int unsigned PW   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            save_req,
  input  logic            restore_req,
  input  logic            ptr_ld,
  input  logic [PW-1:0]   ptr_val,
  input  logic            mask_ld,
  input  logic [NWIN-1:0] mask_val,
  output logic [PW-1:0]   ptr_q,
  output logic [NWIN-1:0] mask_q,
  output logic            trap_q,
  output trap_code_e      code_q
);
  logic [PW-1:0]   ptr_d;
  logic [NWIN-1:0] mask_d;
  logic            trap_d;
  trap_code_e      code_d;
  logic [PW-1:0]   tgt_dn;
  logic [PW-1:0]   tgt_up;
  logic            go_save;
  logic            go_rest;

  always_comb begin
    tgt_dn  = ptr_q - PW'(1);
    tgt_up  = ptr_q + PW'(1);
    go_save = save_req && !restore_req && !ptr_ld;
    go_rest = restore_req && !save_req && !ptr_ld;
    ptr_d   = ptr_q;
    trap_d  = 1'b0;
    code_d  = TRAP_NONE;
    if (ptr_ld) begin
      ptr_d = ptr_val;
    end else if (go_save) begin
      if (mask_q[tgt_dn]) begin
        trap_d = 1'b1;
        code_d = TRAP_OVF;
      end else begin
        ptr_d = tgt_dn;
      end
    end else if (go_rest) begin
      if (mask_q[tgt_up]) begin
        trap_d = 1'b1;
        code_d = TRAP_UNF;
      end else begin
        ptr_d = tgt_up;
      end
    end
    mask_d = mask_ld ? mask_val : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      mask_q <= '0;
      trap_q <= 1'b0;
      code_q <= TRAP_NONE;
    end else begin
      ptr_q  <= ptr_d;
      mask_q <= mask_d;
      trap_q <= trap_d;
      code_q <= code_d;
    end
  end
endmodule

// File: rtl/wrf_rst_sync.sv
module wrf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '0;
    end else begin
      stg <= {stg[0], 1'b1};
    end
  end

  assign rst_n_sync = stg[1];
endmodule

// File: rtl/wrf_top.sv
module wrf_top
  import wrf_pkg::*;
#(
  parameter int unsigned NWIN = 8,
  parameter int unsigned XLEN = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [4:0]       rd_a_idx,
  output logic [XLEN-1:0]  rd_a_data,
  input  logic [4:0]       rd_b_idx,
  output logic [XLEN-1:0]  rd_b_data,
  input  logic             wr_en,
  input  logic [4:0]       wr_idx,
  input  logic [XLEN-1:0]  wr_data,
  input  logic             save_req,
  input  logic             restore_req,
  input  logic             cwp_wr_en,
  input  logic [4:0]       cwp_wr_val,
  input  logic             wim_wr_en,
  input  logic [31:0]      wim_wr_val,
  output logic [4:0]       cwp,
  output logic [31:0]      wim,
  output logic             trap_valid,
  output logic [1:0]       trap_code
);
  localparam int unsigned PW    = $clog2(NWIN);
  localparam int unsigned DEPTH = GRP + NWIN * 2 * GRP;
  localparam int unsigned AW    = $clog2(DEPTH);
  localparam int unsigned NMAP  = 3;

  logic                  rst_n_sync;
  logic [PW-1:0]         ptr_q;
  logic [NWIN-1:0]       mask_q;
  logic                  trap_q;
  trap_code_e            code_q;
  logic [IDX_W-1:0]      map_idx  [NMAP];
  logic [AW-1:0]         map_phys [NMAP];
  logic [NMAP-1:0]       map_zero;
  logic [1:0][AW-1:0]    rd_phys;
  logic [1:0]            rd_zero;
  logic [1:0][XLEN-1:0]  rd_val;
  logic                  wr_ok;

  wrf_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  wrf_window_ctl #(.NWIN(NWIN), .PW(PW)) u_ctl (
    .clk         (clk),
    .rst_n       (rst_n_sync),
    .save_req    (save_req),
    .restore_req (restore_req),
    .ptr_ld      (cwp_wr_en),
    .ptr_val     (cwp_wr_val[PW-1:0]),
    .mask_ld     (wim_wr_en),
    .mask_val    (wim_wr_val[NWIN-1:0]),
    .ptr_q       (ptr_q),
    .mask_q      (mask_q),
    .trap_q      (trap_q),
    .code_q      (code_q)
  );

  assign map_idx[0] = rd_a_idx;
  assign map_idx[1] = rd_b_idx;
  assign map_idx[2] = wr_idx;

  for (genvar m = 0; m < NMAP; m++) begin : g_map
    wrf_addr_map #(.PW(PW), .AW(AW)) u_map (
      .idx     (map_idx[m]),
      .ptr     (ptr_q),
      .phys    (map_phys[m]),
      .is_zero (map_zero[m])
    );
  end

  assign rd_phys = {map_phys[1], map_phys[0]};
  assign rd_zero = map_zero[1:0];
  assign wr_ok   = wr_en && !map_zero[2];

  wrf_storage #(.XLEN(XLEN), .DEPTH(DEPTH), .AW(AW), .NRD(2)) u_mem (
    .clk   (clk),
    .we    (wr_ok),
    .waddr (map_phys[2]),
    .wdata (wr_data),
    .raddr (rd_phys),
    .rzero (rd_zero),
    .rdata (rd_val)
  );

  assign rd_a_data  = rd_val[0];
  assign rd_b_data  = rd_val[1];
  assign cwp        = 5'(ptr_q);
  assign wim        = 32'(mask_q);
  assign trap_valid = trap_q;
  assign trap_code  = code_q;
endmodule

// File: rtl/wrf_checker.sv
module wrf_checker #(
  parameter int unsigned NWIN = 8,
  parameter int unsigned XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic [4:0]      rd_a_idx,
  input logic [XLEN-1:0] rd_a_data,
  input logic [4:0]      rd_b_idx,
  input logic [XLEN-1:0] rd_b_data,
  input logic            wr_en,
  input logic [4:0]      wr_idx,
  input logic [XLEN-1:0] wr_data,
  input logic            save_req,
  input logic            restore_req,
  input logic            cwp_wr_en,
  input logic [4:0]      cwp,
  input logic [31:0]     wim,
  input logic            trap_valid,
  input logic [1:0]      trap_code
);
  localparam int unsigned PW = $clog2(NWIN);

  logic [PW-1:0] dn_tgt;
  logic [PW-1:0] up_tgt;
  logic          lone_save;
  logic          lone_rest;

  assign dn_tgt    = cwp[PW-1:0] - PW'(1);
  assign up_tgt    = cwp[PW-1:0] + PW'(1);
  assign lone_save = save_req && !restore_req && !cwp_wr_en;
  assign lone_rest = restore_req && !save_req && !cwp_wr_en;

  AST_ZERO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == 5'd0) |-> (rd_a_data == '0)); // R3

  AST_BYPASS_A: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx != 5'd0 && wr_idx == rd_a_idx) |-> (rd_a_data == wr_data)); // R10

  AST_BYPASS_B: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx != 5'd0 && wr_idx == rd_b_idx) |-> (rd_b_data == wr_data)); // R10

  AST_SAVE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (lone_save && !wim[dn_tgt]) |=> (cwp[PW-1:0] == $past(dn_tgt) && !trap_valid)); // R4

  AST_RESTORE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (lone_rest && !wim[up_tgt]) |=> (cwp[PW-1:0] == $past(up_tgt) && !trap_valid)); // R5

  AST_NO_OVERFLOW_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (lone_save && wim[dn_tgt]) |=> (trap_valid && trap_code == 2'b01 && $stable(cwp))); // R6

  AST_NO_UNDERFLOW_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (lone_rest && wim[up_tgt]) |=> (trap_valid && trap_code == 2'b10 && $stable(cwp))); // R6

  AST_CODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_valid |-> (trap_code == 2'b00)); // R6

  AST_BOTH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (save_req && restore_req && !cwp_wr_en) |=> ($stable(cwp) && !trap_valid)); // R9

  AST_HIGH_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (cwp[4:3] == 2'b00) && (wim[31:8] == 24'd0)); // R7
endmodule

bind wrf_top wrf_checker #(.NWIN(NWIN), .XLEN(XLEN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n_sync),
  .rd_a_idx    (rd_a_idx),
  .rd_a_data   (rd_a_data),
  .rd_b_idx    (rd_b_idx),
  .rd_b_data   (rd_b_data),
  .wr_en       (wr_en),
  .wr_idx      (wr_idx),
  .wr_data     (wr_data),
  .save_req    (save_req),
  .restore_req (restore_req),
  .cwp_wr_en   (cwp_wr_en),
  .cwp         (cwp),
  .wim         (wim),
  .trap_valid  (trap_valid),
  .trap_code   (trap_code)
);

// File: tb/tb_wrf_top.sv
module tb_wrf_top;
  logic        clk;
  logic        rst_n;
  logic [4:0]  rd_a_idx, rd_b_idx, wr_idx, cwp_wr_val;
  logic [63:0] rd_a_data, rd_b_data, wr_data;
  logic        wr_en, save_req, restore_req, cwp_wr_en, wim_wr_en;
  logic [31:0] wim_wr_val;
  logic [4:0]  cwp;
  logic [31:0] wim;
  logic        trap_valid;
  logic [1:0]  trap_code;

  int          n_chk;
  int          n_fail;
  bit          done;

  logic [63:0] m_mem [136];
  bit          m_val [136];
  int          m_cwp;
  logic [7:0]  m_wim;
  bit          e_trap;
  logic [1:0]  e_code;
  string       pend_tag;

  wrf_top dut (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int map_phys(input int idx, input int w);
    int grp;
    int k;
    grp = idx / 8;
    k   = idx % 8;
    case (grp)
      0:       return k;
      1:       return 8 + ((w + 7) % 8) * 16 + 8 + k;
      2:       return 8 + w * 16 + k;
      default: return 8 + w * 16 + 8 + k;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_rd(input string port, input logic [4:0] ra, input logic [63:0] act);
    int p;
    p = map_phys(int'(ra), m_cwp);
    if (ra == 5'd0) chk({"R3 zero read ", port}, act, 64'd0);
    else if (wr_en && wr_idx == ra) chk({"R10 bypass ", port}, act, wr_data);
    else if (m_val[p]) chk((port == "A") ? "R2 read A" : "R11 read B", act, m_mem[p]);
  endtask

  task automatic step(input logic [4:0] ra, input logic [4:0] rb, input logic we,
                      input logic [4:0] wi, input logic [63:0] wd, input logic sv,
                      input logic rs, input logic cw, input logic [4:0] cv,
                      input logic ww, input logic [31:0] wv);
    int tgt;
    @(negedge clk);
    chk({pend_tag, " cwp"}, 64'(cwp), 64'(m_cwp));
    chk("R8 wim", 64'(wim), 64'(m_wim));
    chk({pend_tag, " trap_valid"}, 64'(trap_valid), 64'(e_trap));
    chk("R6 trap_code", 64'(trap_code), 64'(e_code));
    rd_a_idx = ra; rd_b_idx = rb; wr_en = we; wr_idx = wi; wr_data = wd;
    save_req = sv; restore_req = rs; cwp_wr_en = cw; cwp_wr_val = cv;
    wim_wr_en = ww; wim_wr_val = wv;
    #1;
    chk_rd("A", ra, rd_a_data);
    chk_rd("B", rb, rd_b_data);
    if (we && wi != 5'd0) begin
      m_mem[map_phys(int'(wi), m_cwp)] = wd;
      m_val[map_phys(int'(wi), m_cwp)] = 1'b1;
    end
    e_trap = 1'b0; e_code = 2'b00; pend_tag = "R4";
    if (cw) begin
      m_cwp = int'(cv) % 8; pend_tag = "R7";
    end else if (sv && rs) begin
      pend_tag = "R9";
    end else if (sv) begin
      tgt = (m_cwp + 7) % 8;
      if (m_wim[tgt]) begin e_trap = 1'b1; e_code = 2'b01; pend_tag = "R6"; end
      else m_cwp = tgt;
    end else if (rs) begin
      tgt = (m_cwp + 1) % 8;
      if (m_wim[tgt]) begin e_trap = 1'b1; e_code = 2'b10; pend_tag = "R6"; end
      else begin m_cwp = tgt; pend_tag = "R5"; end
    end
    if (ww) m_wim = wv[7:0];
  endtask

  task automatic idle(input logic [4:0] ra, input logic [4:0] rb);
    step(ra, rb, 1'b0, 5'd0, 64'd0, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0, 32'd0);
  endtask

  task automatic wr(input logic [4:0] wi, input logic [63:0] wd);
    step(5'd0, 5'd0, 1'b1, wi, wd, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    for (int i = 0; i < 136; i++) m_val[i] = 1'b0;
    m_cwp = 0; m_wim = 8'd0; e_trap = 1'b0; e_code = 2'b00; pend_tag = "R1";
    rst_n = 1'b0;
    rd_a_idx = '0; rd_b_idx = '0; wr_en = 1'b0; wr_idx = '0; wr_data = '0;
    save_req = 1'b0; restore_req = 1'b0; cwp_wr_en = 1'b0; cwp_wr_val = '0;
    wim_wr_en = 1'b0; wim_wr_val = '0;
    void'($urandom(32'd2718));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset cwp", 64'(cwp), 64'd0);
    chk("R1 reset wim", 64'(wim), 64'd0);
    chk("R1 reset trap", 64'(trap_valid), 64'd0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R2 globals, outs, locals, ins; then wrap save from window 0 to 7
    wr(5'd5,  64'hAAAA_0005);
    wr(5'd9,  64'hBBBB_0009);
    wr(5'd17, 64'hCCCC_0011);
    wr(5'd25, 64'hDDDD_0019);
    step(5'd0, 5'd0, 1'b0, 5'd0, 64'd0, 1'b1, 1'b0, 1'b0, 5'd0, 1'b0, 32'd0);
    idle(5'd25, 5'd5);
    idle(5'd17, 5'd9);
    // R3 write to index 0 discarded
    wr(5'd0, 64'hFFFF_FFFF_FFFF_FFFF);
    idle(5'd0, 5'd0);
    // R8 upper mask bits dropped; R6 overflow on save to window 6
    step(5'd0, 5'd0, 1'b0, 5'd0, 64'd0, 1'b0, 1'b0, 1'b0, 5'd0, 1'b1, 32'hFFFF_FF40);
    step(5'd0, 5'd0, 1'b0, 5'd0, 64'd0, 1'b1, 1'b0, 1'b0, 5'd0, 1'b0, 32'd0);
    idle(5'd25, 5'd9);
    // R5 restore 7->0->1, then R6 underflow at window 2
    step(5'd0, 5'd0, 1'b0, 5'd0, 64'd0, 1'b0, 1'b1, 1'b0, 5'd0, 1'b0, 32'd0);
    step(5'd0, 5'd0, 1'b0, 5'd0, 64'd0, 1'b0, 1'b1, 1'b0, 5'd0, 1'b1, 32'h0000_0004);
    step(5'd0, 5'd0, 1'b0, 5'd0, 64'd0, 1'b0, 1'b1, 1'b0, 5'd0, 1'b0, 32'd0);
    idle(5'd0, 5'd0);
    // R7 pointer load 13 wins over save
    step(5'd0, 5'd0, 1'b0, 5'd0, 64'd0, 1'b1, 1'b0, 1'b1, 5'd13, 1'b0, 32'd0);
    // R9 both strobes
    step(5'd0, 5'd0, 1'b0, 5'd0, 64'd0, 1'b1, 1'b1, 1'b0, 5'd0, 1'b0, 32'd0);
    // R10 bypass on both ports; R11 independent ports
    step(5'd20, 5'd20, 1'b1, 5'd20, 64'h1234_5678_9ABC_DEF0, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0, 32'd0);
    idle(5'd20, 5'd5);
    // R8 mask load with save in same cycle: old mask used, target 4 invalid only afterwards
    step(5'd0, 5'd0, 1'b0, 5'd0, 64'd0, 1'b1, 1'b0, 1'b0, 5'd0, 1'b1, 32'h0000_0010);
    step(5'd0, 5'd0, 1'b0, 5'd0, 64'd0, 1'b0, 1'b0, 1'b0, 5'd0, 1'b1, 32'd0);

    for (int n = 0; n < 4000; n++) begin
      logic [4:0] ra, rb, wi;
      logic we, sv, rs, cw, ww;
      logic [31:0] wv;
      ra = 5'($urandom); rb = 5'($urandom); wi = 5'($urandom);
      if ($urandom % 6 == 0) ra = wi;
      we = ($urandom % 3) != 0;
      sv = ($urandom % 4) == 0;
      rs = ($urandom % 4) == 0;
      cw = ($urandom % 40) == 0;
      ww = ($urandom % 25) == 0;
      wv = $urandom & $urandom & $urandom;
      step(ra, rb, we, wi, {$urandom, $urandom}, sv, rs, cw, 5'($urandom), ww, wv);
    end
    idle(5'd0, 5'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule